// File: doc/BRIEF.md
# Read-Armed Interrupt Flag Register

This block collects completion events from a multi-buffer message controller and keeps them as sticky flags that software can see and clear over a small register bus. Each of sixteen message buffers owns one flag bit. Three further flags record global conditions (bus-off, error, wake-up) in a separate status register. Event pulses from the controller set flags. Each flag group has its own mask bits, and any flag that is set and unmasked drives a single interrupt line.

Software clears a flag in two steps. First it reads the register and sees the bit as one. Then it writes a one to that bit. The read arms the bit. The write clears only armed bits. A new event on the same bit after the read and before the write disarms it, so an event that arrives while the handler runs is never lost.

Reads are combinational. `bus_rdata` is valid during the cycle `bus_rd` is high, and the arming happens at the edge that ends that cycle. Writes take effect at the edge that ends the write cycle.

Top module: `irq_flag_unit`

## Requirements
- R1: After a synchronous reset, every flag, armed bit, mask and control bit is zero and `irq` is low. A read of any address returns zero.
- R2: An event pulse on `buf_evt[i]` sets bit i of the buffer flag register (address 0) at the next clock edge. The flag stays set until it is cleared.
- R3: A read of address 0 that returns bit i as one arms bit i. A later write to address 0 with `bus_wdata[i]`=1 clears that bit and only that bit. A flag can be armed only while it is set.
- R4: A write of one to a flag that is not armed leaves the flag set. This includes a flag whose read happened while it was still zero.
- R5: Writing zero to a flag bit never changes that flag.
- R6: An event on bit i disarms bit i. A clearing write that follows such an event, with no new read in between, leaves the flag set.
- R7: When an event and a qualifying clearing write reach the same bit in the same cycle, the flag stays set.
- R8: The status register (address 2) holds bus-off in bit 0, error in bit 1 and wake-up in bit 2. These flags are set by `busoff_evt`, `err_evt` and `wake_evt`. They follow the same read-to-arm, write-one-to-clear rule. Reads of address 0 do not arm them.
- R9: Address 1 is a read/write buffer mask register. `irq` is high whenever some buffer flag and its mask bit are both one.
- R10: The control register (address 3) holds the bus-off mask in bit 0 and the error mask in bit 1. The configuration register (address 4) holds the wake-up mask in bit 0. `irq` also rises for any status flag whose mask is set. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe; arms flags read as one |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| buf_evt | input | 16 | Per-buffer completion event pulses |
| busoff_evt | input | 1 | Bus-off event pulse |
| err_evt | input | 1 | Error event pulse |
| wake_evt | input | 1 | Wake-up event pulse |
| irq | output | 1 | Combined masked interrupt |

## Verification
Two functions can fall in the same cycle: a new event pulse on a bit, and a clearing write to that bit. The bench arms a bit with a read. It then raises the event and the write-one strobe in the same cycle, and reads the flag back expecting it still set. It also places an event strictly between the arming read and the write, and checks that the write then leaves the flag set because the bit was disarmed. Every bit passes through the full set, unarmed-write, arm and clear sequence in a sweep. The mask sweep covers every flag-and-mask pairing.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    localparam int NBUF_DEF = 16;
    localparam int DW_DEF   = 16;
    localparam int AW       = 3;
    localparam int NGLOB    = 3;

    typedef enum logic [AW-1:0] {
        A_BFLAG = 3'd0,
        A_BMASK = 3'd1,
        A_STAT  = 3'd2,
        A_CTRL  = 3'd3,
        A_CFG   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic wake;
        logic err;
        logic busoff;
    } glob_vec_t;

    function automatic logic addr_hit(input logic [AW-1:0] a, input reg_addr_e r);
        return a == r;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         rd_hit,
    input  logic         wr_hit,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flags,
    output logic [W-1:0] armed
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic clr;
        assign clr = wr_hit && wdata[i] && armed[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
                armed[i] <= 1'b0;
            end else begin
                flags[i] <= evt[i] | (flags[i] & ~clr);
                if (evt[i] || clr)
                    armed[i] <= 1'b0;
                else if (rd_hit && flags[i])
                    armed[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int W = 16
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] mask,
    output logic         irq
);
    assign irq = |(flags & mask);
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irq_flag_pkg::*;
#(
    parameter int NBUF = NBUF_DEF,
    parameter int DW   = DW_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NBUF-1:0] buf_evt,
    input  logic            busoff_evt,
    input  logic            err_evt,
    input  logic            wake_evt,
    output logic            irq
);
    logic [NBUF-1:0]  bflag, barm, bmask;
    logic [NGLOB-1:0] gflag, garm, gmask;
    logic [1:0]       ctrl_q;
    logic             cfg_q;
    glob_vec_t        gevt;
    logic             buf_irq, glob_irq;

    assign gevt.busoff = busoff_evt;
    assign gevt.err    = err_evt;
    assign gevt.wake   = wake_evt;

    irq_flag_bank #(.W(NBUF)) u_buf (
        .clk(clk), .rst(rst), .evt(buf_evt),
        .rd_hit(bus_rd && addr_hit(bus_addr, A_BFLAG)),
        .wr_hit(bus_wr && addr_hit(bus_addr, A_BFLAG)),
        .wdata(bus_wdata[NBUF-1:0]), .flags(bflag), .armed(barm)
    );

    irq_flag_bank #(.W(NGLOB)) u_glob (
        .clk(clk), .rst(rst), .evt(gevt),
        .rd_hit(bus_rd && addr_hit(bus_addr, A_STAT)),
        .wr_hit(bus_wr && addr_hit(bus_addr, A_STAT)),
        .wdata(bus_wdata[NGLOB-1:0]), .flags(gflag), .armed(garm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bmask  <= '0;
            ctrl_q <= '0;
            cfg_q  <= 1'b0;
        end else if (bus_wr) begin
            if (addr_hit(bus_addr, A_BMASK)) bmask  <= bus_wdata[NBUF-1:0];
            if (addr_hit(bus_addr, A_CTRL))  ctrl_q <= bus_wdata[1:0];
            if (addr_hit(bus_addr, A_CFG))   cfg_q  <= bus_wdata[0];
        end
    end

    assign gmask = {cfg_q, ctrl_q};

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_BFLAG: bus_rdata[NBUF-1:0]  = bflag;
            A_BMASK: bus_rdata[NBUF-1:0]  = bmask;
            A_STAT:  bus_rdata[NGLOB-1:0] = gflag;
            A_CTRL:  bus_rdata[1:0]       = ctrl_q;
            A_CFG:   bus_rdata[0]         = cfg_q;
            default: bus_rdata = '0;
        endcase
    end

    irq_merge #(.W(NBUF))  u_bmrg (.flags(bflag), .mask(bmask), .irq(buf_irq));
    irq_merge #(.W(NGLOB)) u_gmrg (.flags(gflag), .mask(gmask), .irq(glob_irq));

    assign irq = buf_irq | glob_irq;
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk
    import irq_flag_pkg::*;
#(
    parameter int NBUF = NBUF_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_wr,
    input logic [NBUF-1:0]  bus_wdata,
    input logic [NBUF-1:0]  buf_evt,
    input logic [NBUF-1:0]  bflag,
    input logic [NBUF-1:0]  barm,
    input logic [NGLOB-1:0] gflag,
    input logic [NGLOB-1:0] garm
);
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (buf_evt != 0) |=> ((bflag & $past(buf_evt)) == $past(buf_evt)));

    p_arm_needs_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (barm != 0) |-> ((barm & ~bflag) == 0));

    p_fall_needs_arm_r4: assert property (@(posedge clk) disable iff (rst)
        (bflag != 0) |=> (($past(bflag) & ~bflag & ~$past(barm)) == 0));

    p_zero_write_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_BFLAG && bus_wdata == 0) |=> (($past(bflag) & ~bflag) == 0));

    p_evt_disarms_r6: assert property (@(posedge clk) disable iff (rst)
        (buf_evt != 0) |=> ((barm & $past(buf_evt)) == 0));

    p_stat_fall_needs_arm_r8: assert property (@(posedge clk) disable iff (rst)
        (gflag != 0) |=> (($past(gflag) & ~gflag & ~$past(garm)) == 0));
endmodule

bind irq_flag_unit irq_flag_chk #(.NBUF(NBUF)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata[NBUF-1:0]), .buf_evt(buf_evt),
    .bflag(bflag), .barm(barm), .gflag(gflag), .garm(garm)
);

// File: tb/sim_irq_flag_unit.sv
module sim_irq_flag_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] buf_evt = '0;
    logic        busoff_evt = 1'b0, err_evt = 1'b0, wake_evt = 1'b0;
    logic        irq;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_flag_unit u0 (.*);

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
        logic [15:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic bevt(input logic [15:0] v);
        buf_evt = v; tick(); buf_evt = '0;
    endtask

    task automatic gevt(input int g);
        busoff_evt = (g == 0); err_evt = (g == 1); wake_evt = (g == 2);
        tick();
        busoff_evt = 1'b0; err_evt = 1'b0; wake_evt = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        tick(); tick();
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk(a[2:0], 16'h0, "R1");
        chk("R1 irq", {15'd0, irq}, 16'h0);

        // R2/R3/R4/R5 sweep over each buffer bit
        for (int i = 0; i < 16; i++) begin
            bevt(16'h1 << i);
            wr(3'd0, 16'h1 << i);                     // unarmed write: R4
            rd_chk(3'd0, 16'h1 << i, "R2/R4");        // also arms
            wr(3'd0, 16'h0);                          // R5
            rd_chk(3'd0, 16'h1 << i, "R5");
            wr(3'd0, 16'hFFFF);                       // R3 clear
            rd_chk(3'd0, 16'h0, "R3");
        end

        // R4 read while zero does not arm
        rd(3'd0, d);
        bevt(16'h0008);
        wr(3'd0, 16'h0008);
        rd_chk(3'd0, 16'h0008, "R4 read-while-zero");
        wr(3'd0, 16'h0008);
        rd_chk(3'd0, 16'h0, "R3");

        // R3 only written bit clears
        bevt(16'h0006);
        rd(3'd0, d);
        wr(3'd0, 16'h0002);
        rd_chk(3'd0, 16'h0004, "R3 selective");
        wr(3'd0, 16'h0004);
        rd_chk(3'd0, 16'h0, "R3");

        // R6 event between read and write
        bevt(16'h0020);
        rd(3'd0, d);
        bevt(16'h0020);
        wr(3'd0, 16'h0020);
        rd_chk(3'd0, 16'h0020, "R6");
        wr(3'd0, 16'h0020);
        rd_chk(3'd0, 16'h0, "R6 later clear");

        // R7 event and clearing write in same cycle
        bevt(16'h0080);
        rd(3'd0, d);
        buf_evt = 16'h0080;
        wr(3'd0, 16'h0080);
        buf_evt = '0;
        rd_chk(3'd0, 16'h0080, "R7");
        wr(3'd0, 16'h0080);
        rd_chk(3'd0, 16'h0, "R7 later clear");

        // R8 status flags
        for (int g = 0; g < 3; g++) begin
            gevt(g);
            wr(3'd2, 16'h0007);
            rd(3'd0, d);
            wr(3'd2, 16'h0007);
            rd_chk(3'd2, 16'h1 << g, "R8 unarmed");
            wr(3'd2, 16'h0007);
            rd_chk(3'd2, 16'h0, "R8 clear");
        end

        // R9 mask sweep
        for (int i = 0; i < 16; i++) begin
            bevt(16'h1 << i);
            for (int j = 0; j < 16; j++) begin
                wr(3'd1, 16'h1 << j);
                chk("R9 irq", {15'd0, irq}, {15'd0, i == j});
            end
            rd_chk(3'd1, 16'h8000, "R9 mask readback");
            rd(3'd0, d);
            wr(3'd0, 16'h1 << i);
        end
        wr(3'd1, 16'h0);

        // R10 status masks
        for (int g = 0; g < 3; g++) begin
            gevt(g);
            for (int m = 0; m < 8; m++) begin
                wr(3'd3, {14'd0, m[1:0]});
                wr(3'd4, {15'd0, m[2]});
                chk("R10 irq", {15'd0, irq}, {15'd0, m[g]});
            end
            rd(3'd2, d);
            wr(3'd2, 16'h0007);
        end
        rd_chk(3'd3, 16'h0003, "R10 ctrl readback");
        rd_chk(3'd4, 16'h0001, "R10 cfg readback");
        rd_chk(3'd6, 16'h0000, "R10 unused addr");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule